// File: doc/BRIEF.md
# Processor-Driven Configuration Loader

This block is a memory-mapped bus slave through which a processor pushes a configuration image into the byte-wide load port of a programmable-logic region. Software first writes a fixed 32-bit key to release a write lock. It then sets a clock ratio and requests a configuration cycle. After that it streams 32-bit words into a data register. The block holds one word at a time and breaks it into bytes. It presents one byte on each rising edge of a download clock that it derives from the bus clock.

While its one-word buffer is occupied, or while the target is being reset at the start of a cycle, the block inserts wait states on further data writes, so no word is lost. A status register reports the lock, the running cycle, busy, completion into user mode, a latched error, and three live error-source bits. The error sources come from pins for JTAG configuration and external configuration, and from a zero clock ratio. A bitstream-error pin from the target aborts the cycle. A done pin ends the cycle once every byte has been delivered.

Top module: `cfg_loader`

## Requirements
- R1: After reset the block is locked: status bit 0 reads 1. While locked, a bus write to the status/control register (offset 0x140) or the ratio register (offset 0x144) completes with an error response and changes nothing. Writing exactly 0x554E4C4B to offset 0x14C clears the lock, and any other value leaves it set. Writing a 1 to bit 0 of the control register while unlocked sets the lock again.
- R2: Status/control at offset 0x140 reads bit 0 lock, bit 1 configure, bit 2 busy, bit 3 configured, bit 4 latched error, bits 7:5 error source, with all other bits zero. Ratio at offset 0x144 reads back its 8-bit value. The data register (offset 0x148) and the key register both read as zero.
- R3: Writing 1 to bit 1 of the control register while it is unlocked, idle and with error source zero does four things. It sets configure, clears configured and clears the latched error. It also holds busy for RESET_CYCLES bus clocks while the target is being reset.
- R4: A data write while configure and busy are both set is held with wait states (ready low) until the buffer is free, and is then taken. A data write while configure is clear completes with no wait state and is discarded, so no byte leaves the block.
- R5: Each accepted word leaves least significant byte first. One byte goes out per download-clock rising edge, marked by a byte-valid strobe one bus clock wide that coincides with the download clock being high.
- R6: The download clock toggles every RATIO bus clocks, so consecutive bytes are 2×RATIO bus clocks apart. With RATIO zero, the download clock stays low and no byte is sent.
- R7: The error-source field is the live OR of 001 (JTAG configuration pin high), 010 (ratio zero) and 100 (external configuration pin high).
- R8: A configure request made while the error source is nonzero sets the latched error and does not start a cycle. The latched error stays set until a configure request is made with the error source at zero.
- R9: A high bitstream-error pin during a cycle sets the latched error, clears configure and discards buffered data, so no further bytes are sent.
- R10: Once the buffer is empty, outside the reset phase, with the done pin high at a clock edge, configure clears and configured is set at that same edge. Configure and configured are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Bus transfer request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address within the block |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady on reads |
| busReady | output | 1 | Transfer completes at the clock edge where this is high |
| busErr | output | 1 | Error response, valid with busReady |
| jtagBusy | input | 1 | JTAG configuration in progress |
| extCfgBusy | input | 1 | External configuration interface active |
| tgtErr | input | 1 | Bitstream error from the target |
| tgtDone | input | 1 | Target reports configuration complete |
| tgtClk | output | 1 | Download clock |
| tgtData | output | 8 | Configuration byte |
| tgtValid | output | 1 | Byte strobe, one bus clock wide |

## Verification
Responses on the bus are combinational, so busReady, busErr and the read data are sampled one time unit after the request is driven in the low phase. The request is then held across the next rising edge, and any state change from a write shows up in the next transfer. A byte is registered at the edge where the download clock rises, so the bench logs tgtValid and tgtData at falling edges and compares both the order and the clock-count spacing of 2×RATIO. Completion is checked with a status read in the low phase that follows the edge at which done was first sampled high. Abort, idle-write and stopped-clock cases are checked by counting strobes and clock levels over a fixed window of falling edges.

// File: rtl/cfgldr_pkg.sv
package cfgldr_pkg;
  localparam int BYTE_W = 8;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadWord;  // capture a bus word into the buffer
    logic flush;     // drop buffered data
    logic shiftEn;   // bytes may leave on download-clock ticks
  } dpStrobe_t;
endpackage

// File: rtl/cfg_ldr_datapath.sv
module cfg_ldr_datapath
  import cfgldr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [DATA_W-1:0]  wordIn,
  input  logic [RATIO_W-1:0] ratio,
  output logic               bufFull,
  output logic               tgtClk,
  output logic [BYTE_W-1:0]  tgtData,
  output logic               tgtValid
);
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  // Download clock divider
  logic [RATIO_W-1:0] divCnt;
  logic               dlClk;
  logic               ratioZero;
  logic               divWrap;
  logic               riseTick;

  assign ratioZero = (ratio == '0);
  assign divWrap   = !ratioZero && (divCnt >= RATIO_W'(ratio - 1'b1));
  assign riseTick  = divWrap && !dlClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      dlClk  <= 1'b0;
    end else if (ratioZero) begin
      divCnt <= '0;
      dlClk  <= 1'b0;
    end else if (divWrap) begin
      divCnt <= '0;
      dlClk  <= ~dlClk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tgtClk = dlClk;

  // Word buffer split into byte lanes
  logic [DATA_W-1:0] wordBuf;
  logic [BYTE_W-1:0] lane [LANES];
  logic [LANE_W-1:0] laneIdx;
  logic              full;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = wordBuf[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordBuf  <= '0;
      laneIdx  <= '0;
      full     <= 1'b0;
      tgtData  <= '0;
      tgtValid <= 1'b0;
    end else begin
      tgtValid <= 1'b0;
      if (strobe.flush) begin
        full    <= 1'b0;
        laneIdx <= '0;
      end else if (strobe.loadWord) begin
        wordBuf <= wordIn;
        full    <= 1'b1;
        laneIdx <= '0;
      end else if (riseTick && full && strobe.shiftEn) begin
        tgtData  <= lane[laneIdx];
        tgtValid <= 1'b1;
        if (laneIdx == LAST_LANE) begin
          full    <= 1'b0;
          laneIdx <= '0;
        end else begin
          laneIdx <= laneIdx + 1'b1;
        end
      end
    end
  end

  assign bufFull = full;
endmodule

// File: rtl/cfg_ldr_ctrl.sv
module cfg_ldr_ctrl
  import cfgldr_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 12,
  parameter int RATIO_W      = 8,
  parameter int RESET_CYCLES = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 12'h140,
  parameter logic [ADDR_W-1:0] RATIO_OFS  = 12'h144,
  parameter logic [ADDR_W-1:0] DATA_OFS   = 12'h148,
  parameter logic [ADDR_W-1:0] KEY_OFS    = 12'h14C,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h554E4C4B
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               busReady,
  output logic               busErr,
  input  logic               jtagBusy,
  input  logic               extCfgBusy,
  input  logic               tgtErr,
  input  logic               tgtDone,
  input  logic               bufFull,
  output dpStrobe_t          strobe,
  output logic [RATIO_W-1:0] ratio,
  output logic               lockedQ,
  output logic               cfgQ,
  output logic               doneQ,
  output logic               busyQ
);
  localparam int RC_W = $clog2(RESET_CYCLES + 1);

  logic [RATIO_W-1:0] ratioQ;
  logic               errQ;
  logic [RC_W-1:0]    resetCnt;
  logic               resetting;
  logic [2:0]         errSrc;

  logic hitCtrl, hitRatio, hitData, hitKey;
  logic wrCtrl, wrRatio, wrData, wrKey;
  logic lockedWrite;
  logic startReq, startOk, startBad;
  logic abortCfg, finishCfg;

  assign hitCtrl  = (busAddr == CTRL_OFS);
  assign hitRatio = (busAddr == RATIO_OFS);
  assign hitData  = (busAddr == DATA_OFS);
  assign hitKey   = (busAddr == KEY_OFS);

  assign resetting = (resetCnt != '0);
  assign busyQ     = cfgQ && (resetting || bufFull);
  assign errSrc    = {extCfgBusy, (ratioQ == '0), jtagBusy};

  // Bus handshake: only data writes can stall
  assign busReady    = !(busValid && busWrite && hitData && busyQ);
  assign lockedWrite = busValid && busWrite && lockedQ && (hitCtrl || hitRatio);
  assign busErr      = lockedWrite;

  assign wrCtrl  = busValid && busWrite && hitCtrl  && !lockedQ;
  assign wrRatio = busValid && busWrite && hitRatio && !lockedQ;
  assign wrData  = busValid && busWrite && hitData  && busReady;
  assign wrKey   = busValid && busWrite && hitKey;

  assign startReq = wrCtrl && busWdata[1] && !cfgQ;
  assign startOk  = startReq && (errSrc == 3'b000);
  assign startBad = startReq && (errSrc != 3'b000);
  assign abortCfg  = cfgQ && tgtErr;
  assign finishCfg = cfgQ && !resetting && !bufFull && tgtDone && !abortCfg;

  always_comb begin
    strobe.loadWord = wrData && cfgQ;
    strobe.flush    = startOk || abortCfg;
    strobe.shiftEn  = cfgQ && !resetting;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockedQ  <= 1'b1;
      cfgQ     <= 1'b0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
      ratioQ   <= '0;
      resetCnt <= '0;
    end else begin
      if (resetting) resetCnt <= resetCnt - 1'b1;

      if (abortCfg) begin
        cfgQ <= 1'b0;
        errQ <= 1'b1;
      end else if (finishCfg) begin
        cfgQ  <= 1'b0;
        doneQ <= 1'b1;
      end

      if (wrKey && (busWdata == UNLOCK_KEY)) lockedQ <= 1'b0;
      if (wrCtrl && busWdata[0]) lockedQ <= 1'b1;
      if (wrRatio) ratioQ <= busWdata[RATIO_W-1:0];

      if (startBad) errQ <= 1'b1;
      if (startOk) begin
        errQ     <= 1'b0;
        cfgQ     <= 1'b1;
        doneQ    <= 1'b0;
        resetCnt <= RC_W'(RESET_CYCLES);
      end
    end
  end

  assign ratio = ratioQ;

  // Read mux
  logic [7:0] statusByte;
  assign statusByte = {errSrc, errQ, doneQ, busyQ, cfgQ, lockedQ};

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite) begin
      if (hitCtrl)       busRdata = DATA_W'(statusByte);
      else if (hitRatio) busRdata = DATA_W'(ratioQ);
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgldr_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 12,
  parameter int RATIO_W      = 8,
  parameter int RESET_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic              busErr,
  input  logic              jtagBusy,
  input  logic              extCfgBusy,
  input  logic              tgtErr,
  input  logic              tgtDone,
  output logic              tgtClk,
  output logic [BYTE_W-1:0] tgtData,
  output logic              tgtValid
);
  dpStrobe_t          strobe;
  logic [RATIO_W-1:0] ratioQ;
  logic               bufFull;
  logic               lockedQ;
  logic               cfgQ;
  logic               doneQ;
  logic               busyQ;

  cfg_ldr_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RATIO_W(RATIO_W), .RESET_CYCLES(RESET_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .busErr(busErr),
    .jtagBusy(jtagBusy), .extCfgBusy(extCfgBusy), .tgtErr(tgtErr), .tgtDone(tgtDone),
    .bufFull(bufFull), .strobe(strobe), .ratio(ratioQ),
    .lockedQ(lockedQ), .cfgQ(cfgQ), .doneQ(doneQ), .busyQ(busyQ)
  );

  cfg_ldr_datapath #(
    .DATA_W(DATA_W), .RATIO_W(RATIO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIn(busWdata), .ratio(ratioQ),
    .bufFull(bufFull), .tgtClk(tgtClk), .tgtData(tgtData), .tgtValid(tgtValid)
  );
endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker #(
  parameter int ADDR_W  = 12,
  parameter int RATIO_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busReady,
  input logic              busErr,
  input logic              tgtClk,
  input logic              tgtValid,
  input logic [RATIO_W-1:0] ratioQ,
  input logic              lockedQ,
  input logic              cfgQ,
  input logic              doneQ,
  input logic              busyQ
);
  // R1: a locked control write must see an error response
  a_r1_locked_ctrl_err: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && lockedQ && busAddr == 12'h140) |-> busErr);

  // R1: an error response always completes the transfer
  a_r1_err_with_ready: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> busReady);

  // R4: data write during busy is stalled
  a_r4_stall_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == 12'h148 && busyQ) |-> !busReady);

  // R5: byte strobe lasts exactly one clock
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid |=> !tgtValid);

  // R5: byte strobe coincides with download clock high
  a_r5_strobe_clk_high: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid |-> tgtClk);

  // R6: zero ratio holds the download clock low
  a_r6_stopped_clk: assert property (@(posedge clk) disable iff (!rstN)
    (ratioQ == '0) |=> !tgtClk);

  // R10: configure and configured are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgQ && doneQ));
endmodule

bind cfg_loader cfg_loader_checker #(.ADDR_W(ADDR_W), .RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .busReady(busReady), .busErr(busErr), .tgtClk(tgtClk), .tgtValid(tgtValid),
  .ratioQ(ratioQ), .lockedQ(lockedQ), .cfgQ(cfgQ), .doneQ(doneQ), .busyQ(busyQ)
);

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [11:0] A_CTRL  = 12'h140;
  localparam logic [11:0] A_RATIO = 12'h144;
  localparam logic [11:0] A_DATA  = 12'h148;
  localparam logic [11:0] A_KEY   = 12'h14C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady, busErr;
  logic        jtagBusy = 1'b0, extCfgBusy = 1'b0, tgtErr = 1'b0, tgtDone = 1'b0;
  logic        tgtClk, tgtValid;
  logic [7:0]  tgtData;

  int nChecks = 0, nErrors = 0;
  int cyc = 0;
  int nBytes = 0;
  logic [7:0] byteLog [32];
  int         byteCyc [32];
  logic prevValid = 1'b0;
  int   dblStrobe = 0, lowStrobe = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_loader u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .busErr(busErr),
    .jtagBusy(jtagBusy), .extCfgBusy(extCfgBusy), .tgtErr(tgtErr), .tgtDone(tgtDone),
    .tgtClk(tgtClk), .tgtData(tgtData), .tgtValid(tgtValid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && tgtValid) begin
      if (nBytes < 32) begin
        byteLog[nBytes] = tgtData;
        byteCyc[nBytes] = cyc;
      end
      nBytes = nBytes + 1;
      if (prevValid) dblStrobe = dblStrobe + 1;
      if (!tgtClk) lowStrobe = lowStrobe + 1;
    end
    prevValid = tgtValid;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      output logic e, output logic [31:0] rd, output int waits);
    waits = 0;
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    #1;
    while (!busReady) begin
      waits++;
      @(negedge clk);
      #1;
    end
    e = busErr; rd = busRdata;
    @(posedge clk);
    #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdReg(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic e; logic [31:0] rd; int w;
    xfer(1'b0, a, '0, e, rd, w);
    chk(req, rd, exp);
  endtask

  task automatic wrReg(input string req, input logic [11:0] a, input logic [31:0] d,
                       input logic expErr);
    logic e; logic [31:0] rd; int w;
    xfer(1'b1, a, d, e, rd, w);
    chk(req, {31'b0, e}, {31'b0, expErr});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic        expErr;
    logic [31:0] expRd;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 12'h140, 32'h0,        1'b0, 32'h41},  // R1 R2 reset: locked, ratio zero source
    '{1'b1, 12'h144, 32'h3,        1'b1, 32'h0},   // R1 locked ratio write errs
    '{1'b0, 12'h144, 32'h0,        1'b0, 32'h0},   // R1 ratio unchanged
    '{1'b1, 12'h140, 32'h2,        1'b1, 32'h0},   // R1 locked control write errs
    '{1'b0, 12'h140, 32'h0,        1'b0, 32'h41},  // R1 control unchanged
    '{1'b1, 12'h14C, 32'h12345678, 1'b0, 32'h0},   // R1 wrong key
    '{1'b0, 12'h140, 32'h0,        1'b0, 32'h41},  // R1 still locked
    '{1'b1, 12'h14C, 32'h554E4C4B, 1'b0, 32'h0},   // R1 right key
    '{1'b0, 12'h140, 32'h0,        1'b0, 32'h40},  // R1 unlocked
    '{1'b1, 12'h140, 32'h2,        1'b0, 32'h0},   // R8 configure with ratio zero
    '{1'b0, 12'h140, 32'h0,        1'b0, 32'h50},  // R8 error latched, no start
    '{1'b1, 12'h144, 32'h2,        1'b0, 32'h0},   // R2 set ratio
    '{1'b0, 12'h144, 32'h0,        1'b0, 32'h2},   // R2 ratio reads back
    '{1'b0, 12'h140, 32'h0,        1'b0, 32'h10},  // R7 source clears, error stays
    '{1'b0, 12'h148, 32'h0,        1'b0, 32'h0}    // R2 data reads zero
  };

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin : main
    logic e; logic [31:0] rd; int w; int base; int n1; int highs;
    logic [7:0] expB [8];
    expB = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hD8, 8'hC7, 8'hB6, 8'hA5};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R5 reset strobe low", {31'b0, tgtValid}, 32'h0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      xfer(VECS[i].wr, VECS[i].addr, VECS[i].data, e, rd, w);
      chk($sformatf("R1/R2/R7/R8 vec%0d err", i), {31'b0, e}, {31'b0, VECS[i].expErr});
      if (!VECS[i].wr) chk($sformatf("R2 vec%0d rdata", i), rd, VECS[i].expRd);
    end

    // R3: start a cycle, busy during reset phase, error cleared
    wrReg("R3 start", A_CTRL, 32'h2, 1'b0);
    rdReg("R3 R8 configure+busy", A_CTRL, 32'h06);

    // R4 R5 R6: two words, second stalls
    base = nBytes;
    xfer(1'b1, A_DATA, 32'h44332211, e, rd, w);
    chk("R4 first word stalled in reset phase", {31'b0, (w > 0)}, 32'h1);
    xfer(1'b1, A_DATA, 32'hA5B6C7D8, e, rd, w);
    chk("R4 second word stalled while full", {31'b0, (w > 0)}, 32'h1);
    for (int t = 0; t < 200 && nBytes < base + 8; t++) @(negedge clk);
    chk("R5 byte count", nBytes - base, 8);
    for (int k = 0; k < 8; k++) begin
      if (base + k < 32) chk($sformatf("R5 byte %0d", k), {24'b0, byteLog[base+k]}, {24'b0, expB[k]});
      if (k > 0 && base + k < 32)
        chk($sformatf("R6 spacing %0d", k), byteCyc[base+k] - byteCyc[base+k-1], 4);
    end
    chk("R5 strobe width", dblStrobe, 0);
    chk("R5 strobe on clk high", lowStrobe, 0);

    // R10 completion
    rdReg("R10 waiting for done", A_CTRL, 32'h02);
    @(negedge clk); tgtDone = 1'b1;
    @(negedge clk); tgtDone = 1'b0;
    rdReg("R10 configured", A_CTRL, 32'h08);

    // R7 R8 error sources
    jtagBusy = 1'b1;
    rdReg("R7 jtag source", A_CTRL, 32'h28);
    wrReg("R8 bad start", A_CTRL, 32'h2, 1'b0);
    rdReg("R8 error latched", A_CTRL, 32'h38);
    extCfgBusy = 1'b1;
    rdReg("R7 jtag+ext source", A_CTRL, 32'hB8);
    jtagBusy = 1'b0; extCfgBusy = 1'b0;
    rdReg("R8 error persists", A_CTRL, 32'h18);
    wrReg("R8 clean start", A_CTRL, 32'h2, 1'b0);
    rdReg("R3 R8 restart clears", A_CTRL, 32'h06);

    // R9 abort
    xfer(1'b1, A_DATA, 32'h99887766, e, rd, w);
    @(negedge clk); tgtErr = 1'b1;
    @(negedge clk); tgtErr = 1'b0;
    n1 = nBytes;
    idle(20);
    chk("R9 no bytes after abort", nBytes, n1);
    rdReg("R9 aborted with error", A_CTRL, 32'h10);

    // R6 R7 stopped clock
    wrReg("R6 ratio zero", A_RATIO, 32'h0, 1'b0);
    rdReg("R7 ratio zero source", A_CTRL, 32'h50);
    highs = 0;
    for (int t = 0; t < 20; t++) begin @(negedge clk); if (tgtClk) highs++; end
    chk("R6 clock stopped", highs, 0);
    wrReg("R6 ratio one", A_RATIO, 32'h1, 1'b0);
    idle(2);
    highs = 0;
    for (int t = 0; t < 20; t++) begin @(negedge clk); if (tgtClk) highs++; end
    chk("R6 ratio one toggles", highs, 10);

    // R4 idle data write
    base = nBytes;
    xfer(1'b1, A_DATA, 32'hDEADBEEF, e, rd, w);
    chk("R4 idle write no wait", w, 0);
    idle(20);
    chk("R4 idle write discarded", nBytes, base);

    // R1 relock
    wrReg("R1 relock", A_CTRL, 32'h1, 1'b0);
    rdReg("R1 relocked", A_CTRL, 32'h11);
    wrReg("R1 locked ratio err", A_RATIO, 32'h5, 1'b1);
    rdReg("R1 ratio kept", A_RATIO, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule